// File: doc/BRIEF.md
# Flash Bank-Mode Address Remapper

This block turns a read request on one of four flash read ports into a physical flash location. The location is given as a flash controller, a bank number and a byte offset inside that bank. The four ports are the CPU1 program port, the CPU3 program port, the firmware-update port and the data-flash port. Program flash is made of four interleaved bank pairs of 1 MB each. Controller 0 holds global pairs 0 and 1, and controller 1 holds global pairs 2 and 3. Controller 0 also has a 256 KB data bank.

Which pair answers a port depends on two things. The first is a bank mode, which is captured once after reset from a boot configuration word. The second is a pair of runtime swap bits, one for each CPU. In the odd modes, the swap bits exchange the running pair set and the pair set that sits behind the update port. This allows code to be reprogrammed while another image executes.

Requests travel as a stream. `rsp_valid` follows `req_valid`, and `req_ready` follows `rsp_ready`. The translation is combinational, so while a request is stalled, its output stays exactly as long as the request inputs stay the same. Back-pressure is never generated by the block itself.

Top module: `flash_bank_remap`

## Requirements
- R1: After reset the mode is 0 and both swap bits are clear. A CPU1 request at offset 0 gives controller 0, bank 0, offset 0, with no error.
- R2: The first `boot_cfg_valid` pulse after reset loads `boot_cfg_mode`. Any later pulse is ignored until the next reset.
- R3: When parameter `CPU3_PRESENT` is 0, a boot value of 2 or 3 is rejected and the mode stays 0.
- R4: Global pair g lives in controller g[1]. Bank = 2*g[0] + offset[4], and offset bit 4 picks the even or odd bank of the pair. The in-bank offset is {offset[19:5], offset[3:0]}.
- R5: Each port's region is a run of pairs, and offset[21:20] selects a pair within that run. The port encoding is 0 = CPU1, 1 = CPU3, 2 = update, 3 = data. The mapping per mode is:
  - Mode 0: CPU1 covers pairs 0..3.
  - Mode 1: CPU1 covers pairs 0,1; the update port covers pairs 2,3.
  - Mode 2: CPU1 covers pairs 0,1; CPU3 covers pairs 2,3.
  - Mode 3: CPU1 covers pair 0; CPU3 covers pair 2; the update port covers pair 1 for selector 0 and pair 3 for selector 1.
- R6: In mode 1 the CPU1 swap bit exchanges the pair set {0,1} with {2,3}. In mode 3 the CPU1 swap bit exchanges pairs 0 and 1, and the CPU3 swap bit exchanges pairs 2 and 3. In both modes the exchange applies between the CPU port and the update port.
- R7: In modes 0 and 2 the swap bits have no effect on any translation.
- R8: A swap write is held back as long as a request is valid on a port it affects. The CPU1 bit is affected by the CPU1 and update ports; the CPU3 bit by the CPU3 and update ports. The write takes effect at the first clock edge with no such request.
- R9: `rsp_err` is 1 in these cases: the selector is beyond the port's region; the CPU3 port is used in mode 0 or 1; the update port is used in mode 0 or 2; or a data offset is 256 KB or more. While `rsp_err` is 1, the controller, bank and offset outputs are 0.
- R10: The data port always maps to controller 0, bank 4, with offset[17:0] as the in-bank offset, whatever the mode or swap state.
- R11: `rsp_valid` equals `req_valid` and `req_ready` equals `rsp_ready`. A stalled request keeps its translation stable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| boot_cfg_valid | input | 1 | Boot configuration word present |
| boot_cfg_mode | input | 2 | Bank mode carried in the boot word |
| swap_wr | input | 1 | Write strobe for the swap bits |
| swap_cpu1 | input | 1 | New CPU1 swap value |
| swap_cpu3 | input | 1 | New CPU3 swap value |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request accepted |
| req_port | input | 2 | Read port: 0 CPU1, 1 CPU3, 2 update, 3 data |
| req_offset | input | 22 | Byte offset within the port |
| rsp_valid | output | 1 | Translation valid |
| rsp_ready | input | 1 | Consumer takes the translation |
| rsp_ctrl | output | 1 | Flash controller index |
| rsp_bank | output | 3 | Bank index within the controller |
| rsp_offset | output | 19 | Byte offset within the bank |
| rsp_err | output | 1 | Unmapped access |

## Verification
The bench uses the same offsets in every mode, so that a wrong pair base or region size shows up as a different controller or bank.

- Offsets that toggle bit 4 separate the even and odd banks.
- Offsets at the top of a region and one step past it separate a correct limit from an off-by-one.
- Swap writes in each mode show whether an exchange happens only where it should.
- A swap write issued under a stalled request shows whether the mapping moves while that request is still pending.
- A second instance built without the third CPU receives the same boot words, which shows that the split modes are rejected.

// File: rtl/flr_pkg.sv
package flr_pkg;
  typedef enum logic [1:0] {
    PORT_CPU1 = 2'd0,
    PORT_CPU3 = 2'd1,
    PORT_UPD  = 2'd2,
    PORT_DATA = 2'd3
  } port_e;

  localparam logic [2:0] DATA_BANK_IDX = 3'd4;
endpackage

// File: rtl/flr_mode_reg.sv
module flr_mode_reg #(
  parameter bit CPU3_PRESENT = 1'b1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cfg_valid,
  input  logic [1:0] cfg_mode,
  output logic [1:0] mode
);
  logic locked_q;
  logic accept_split;

  assign accept_split = CPU3_PRESENT;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode     <= 2'd0;
      locked_q <= 1'b0;
    end else if (cfg_valid && !locked_q) begin
      locked_q <= 1'b1;
      mode     <= (accept_split || !cfg_mode[1]) ? cfg_mode : 2'd0;
    end
  end

  // R2: once a boot word is taken, the mode is frozen
  a_r2_mode_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    locked_q |=> $stable(mode));

  generate
    if (!CPU3_PRESENT) begin : g_no_cpu3
      // R3: split modes never held without the third CPU
      a_r3_no_split_mode: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_valid |=> !mode[1]);
    end
  endgenerate
endmodule

// File: rtl/flr_swap_ctl.sv
module flr_swap_ctl #(
  parameter int LANES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr,
  input  logic [LANES-1:0] wr_val,
  input  logic [LANES-1:0] busy,
  output logic [LANES-1:0] swap
);
  logic [LANES-1:0] pend_q;
  logic [LANES-1:0] pval_q;

  generate
    for (genvar i = 0; i < LANES; i++) begin : g_lane
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          swap[i]   <= 1'b0;
          pend_q[i] <= 1'b0;
          pval_q[i] <= 1'b0;
        end else if (wr) begin
          if (busy[i]) begin
            pend_q[i] <= 1'b1;
            pval_q[i] <= wr_val[i];
          end else begin
            pend_q[i] <= 1'b0;
            swap[i]   <= wr_val[i];
          end
        end else if (pend_q[i] && !busy[i]) begin
          pend_q[i] <= 1'b0;
          swap[i]   <= pval_q[i];
        end
      end

      // R8: mapping never moves under a live request on an affected port
      a_r8_hold_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
        busy[i] |=> $stable(swap[i]));
    end
  endgenerate
endmodule

// File: rtl/flr_xlate.sv
module flr_xlate
  import flr_pkg::*;
#(
  parameter int PAIR_AW  = 20,
  parameter int DATA_AW  = 18,
  parameter int LINE_BIT = 4,
  localparam int OFS_W   = PAIR_AW + 2,
  localparam int BOFS_W  = PAIR_AW - 1
) (
  input  logic [1:0]        mode,
  input  logic              swap1,
  input  logic              swap3,
  input  port_e             port,
  input  logic [OFS_W-1:0]  ofs,
  output logic              err,
  output logic              ctrl,
  output logic [2:0]        bank,
  output logic [BOFS_W-1:0] bofs
);
  logic [1:0] sel;
  logic [2:0] nreg;
  logic [1:0] base;
  logic [1:0] gpair;
  logic       upd_split;
  logic       prog_ok;
  logic       data_ok;
  logic [BOFS_W-1:0] prog_bofs;
  logic [BOFS_W-1:0] data_bofs;

  assign sel       = ofs[OFS_W-1 -: 2];
  assign prog_bofs = {ofs[PAIR_AW-1:LINE_BIT+1], ofs[LINE_BIT-1:0]};
  assign data_bofs = {{(BOFS_W-DATA_AW){1'b0}}, ofs[DATA_AW-1:0]};
  assign data_ok   = (ofs[OFS_W-1:DATA_AW] == '0);

  always_comb begin
    nreg      = 3'd0;
    base      = 2'd0;
    upd_split = 1'b0;
    unique case (port)
      PORT_CPU1: begin
        unique case (mode)
          2'd0: begin nreg = 3'd4; base = 2'd0; end
          2'd1: begin nreg = 3'd2; base = {swap1, 1'b0}; end
          2'd2: begin nreg = 3'd2; base = 2'd0; end
          default: begin nreg = 3'd1; base = {1'b0, swap1}; end
        endcase
      end
      PORT_CPU3: begin
        unique case (mode)
          2'd2: begin nreg = 3'd2; base = 2'd2; end
          2'd3: begin nreg = 3'd1; base = {1'b1, swap3}; end
          default: nreg = 3'd0;
        endcase
      end
      PORT_UPD: begin
        unique case (mode)
          2'd1: begin nreg = 3'd2; base = {~swap1, 1'b0}; end
          2'd3: begin nreg = 3'd2; upd_split = 1'b1; end
          default: nreg = 3'd0;
        endcase
      end
      default: nreg = 3'd0;
    endcase
  end

  always_comb begin
    if (upd_split) gpair = sel[0] ? {1'b1, ~swap3} : {1'b0, ~swap1};
    else           gpair = base + sel;
  end

  assign prog_ok = ({1'b0, sel} < nreg);

  always_comb begin
    err  = 1'b1;
    ctrl = 1'b0;
    bank = 3'd0;
    bofs = '0;
    if (port == PORT_DATA) begin
      if (data_ok) begin
        err  = 1'b0;
        bank = DATA_BANK_IDX;
        bofs = data_bofs;
      end
    end else if (prog_ok) begin
      err  = 1'b0;
      ctrl = gpair[1];
      bank = {1'b0, gpair[0], ofs[LINE_BIT]};
      bofs = prog_bofs;
    end
  end
endmodule

// File: rtl/flash_bank_remap.sv
module flash_bank_remap
  import flr_pkg::*;
#(
  parameter bit CPU3_PRESENT = 1'b1,
  parameter int PAIR_AW      = 20,
  parameter int DATA_AW      = 18,
  parameter int LINE_BIT     = 4,
  localparam int OFS_W       = PAIR_AW + 2,
  localparam int BOFS_W      = PAIR_AW - 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              boot_cfg_valid,
  input  logic [1:0]        boot_cfg_mode,
  input  logic              swap_wr,
  input  logic              swap_cpu1,
  input  logic              swap_cpu3,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [1:0]        req_port,
  input  logic [OFS_W-1:0]  req_offset,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic              rsp_ctrl,
  output logic [2:0]        rsp_bank,
  output logic [BOFS_W-1:0] rsp_offset,
  output logic              rsp_err
);
  port_e      port;
  logic [1:0] mode;
  logic [1:0] swap;
  logic [1:0] busy;

  assign port      = port_e'(req_port);
  assign rsp_valid = req_valid;
  assign req_ready = rsp_ready;

  assign busy[0] = req_valid && (port == PORT_CPU1 || port == PORT_UPD);
  assign busy[1] = req_valid && (port == PORT_CPU3 || port == PORT_UPD);

  flr_mode_reg #(.CPU3_PRESENT(CPU3_PRESENT)) u_mode (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_valid (boot_cfg_valid),
    .cfg_mode  (boot_cfg_mode),
    .mode      (mode)
  );

  flr_swap_ctl #(.LANES(2)) u_swap (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr     (swap_wr),
    .wr_val ({swap_cpu3, swap_cpu1}),
    .busy   (busy),
    .swap   (swap)
  );

  flr_xlate #(.PAIR_AW(PAIR_AW), .DATA_AW(DATA_AW), .LINE_BIT(LINE_BIT)) u_xlate (
    .mode  (mode),
    .swap1 (swap[0]),
    .swap3 (swap[1]),
    .port  (port),
    .ofs   (req_offset),
    .err   (rsp_err),
    .ctrl  (rsp_ctrl),
    .bank  (rsp_bank),
    .bofs  (rsp_offset)
  );

  // R9: the CPU3 port is unmapped in the single-CPU modes
  a_r9_cpu3_unmapped: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && port == PORT_CPU3 && !mode[1]) |-> rsp_err);

  // R10: data requests land only in the data bank of controller 0
  a_r10_data_target: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && port == PORT_DATA && !rsp_err) |-> (!rsp_ctrl && rsp_bank == DATA_BANK_IDX));

  // R9: error responses carry a zero location
  a_r9_err_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && rsp_err) |-> (!rsp_ctrl && rsp_bank == 3'd0 && rsp_offset == '0));

  // R11: a stalled request with unchanged inputs keeps its translation
  a_r11_stall_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !rsp_ready && !swap_wr) ##1 (req_valid && $stable(req_port) && $stable(req_offset))
      |-> ($stable(rsp_bank) && $stable(rsp_ctrl) && $stable(rsp_err)));
endmodule

// File: tb/flash_bank_remap_tb.sv
module flash_bank_remap_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        boot_cfg_valid = 1'b0;
  logic [1:0]  boot_cfg_mode = 2'd0;
  logic        swap_wr = 1'b0;
  logic        swap_cpu1 = 1'b0;
  logic        swap_cpu3 = 1'b0;
  logic        req_valid = 1'b0;
  logic [1:0]  req_port = 2'd0;
  logic [21:0] req_offset = '0;
  logic        rsp_ready = 1'b1;
  logic        req_ready, rsp_valid, rsp_ctrl, rsp_err;
  logic [2:0]  rsp_bank;
  logic [18:0] rsp_offset;
  logic        n_req_ready, n_rsp_valid, n_rsp_ctrl, n_rsp_err;
  logic [2:0]  n_rsp_bank;
  logic [18:0] n_rsp_offset;

  int checks = 0;
  int fails = 0;
  logic [1:0] m_mode = 2'd0;
  logic m_s1 = 1'b0, m_s3 = 1'b0;
  logic [23:0] exp_q[$];
  string tag_q[$];

  always #5 clk = ~clk;

  flash_bank_remap dut_i (
    .clk(clk), .rst_n(rst_n), .boot_cfg_valid(boot_cfg_valid), .boot_cfg_mode(boot_cfg_mode),
    .swap_wr(swap_wr), .swap_cpu1(swap_cpu1), .swap_cpu3(swap_cpu3),
    .req_valid(req_valid), .req_ready(req_ready), .req_port(req_port), .req_offset(req_offset),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_ctrl(rsp_ctrl), .rsp_bank(rsp_bank),
    .rsp_offset(rsp_offset), .rsp_err(rsp_err));

  flash_bank_remap #(.CPU3_PRESENT(1'b0)) dut_n (
    .clk(clk), .rst_n(rst_n), .boot_cfg_valid(boot_cfg_valid), .boot_cfg_mode(boot_cfg_mode),
    .swap_wr(swap_wr), .swap_cpu1(swap_cpu1), .swap_cpu3(swap_cpu3),
    .req_valid(req_valid), .req_ready(n_req_ready), .req_port(req_port), .req_offset(req_offset),
    .rsp_valid(n_rsp_valid), .rsp_ready(rsp_ready), .rsp_ctrl(n_rsp_ctrl), .rsp_bank(n_rsp_bank),
    .rsp_offset(n_rsp_offset), .rsp_err(n_rsp_err));

  // Reference model from R4, R5, R6, R7, R9, R10: {err, ctrl, bank, offset}
  function automatic logic [23:0] model(input logic [1:0] md, input logic s1, input logic s3,
                                        input logic [1:0] p, input logic [21:0] o);
    logic [1:0] sel = o[21:20];
    int n = 0;
    int b = 0;
    int g;
    logic split = 1'b0;
    if (p == 2'd3) begin
      if (o[21:18] == 4'd0) return {1'b0, 1'b0, 3'd4, 1'b0, o[17:0]};
      return 24'h800000;
    end
    case (p)
      2'd0: case (md)
        2'd0: begin n = 4; b = 0; end
        2'd1: begin n = 2; b = s1 ? 2 : 0; end
        2'd2: begin n = 2; b = 0; end
        default: begin n = 1; b = s1 ? 1 : 0; end
      endcase
      2'd1: case (md)
        2'd2: begin n = 2; b = 2; end
        2'd3: begin n = 1; b = s3 ? 3 : 2; end
        default: n = 0;
      endcase
      default: case (md)
        2'd1: begin n = 2; b = s1 ? 0 : 2; end
        2'd3: begin n = 2; split = 1'b1; end
        default: n = 0;
      endcase
    endcase
    if (int'(sel) >= n) return 24'h800000;
    if (split) g = sel[0] ? (s3 ? 2 : 3) : (s1 ? 0 : 1);
    else g = b + int'(sel);
    return {1'b0, g[1], 1'b0, g[0], o[4], o[19:5], o[3:0]};
  endfunction

  task automatic check(input string req, input logic [23:0] act, input logic [23:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  // Monitor: pops the expected item on every accepted translation
  always @(negedge clk) begin
    if (rst_n && rsp_valid && rsp_ready) begin
      checks++;
      if (exp_q.size() == 0) begin
        fails++;
        $display("FAIL R11: unexpected response got %h expected none",
                 {rsp_err, rsp_ctrl, rsp_bank, rsp_offset});
      end else begin
        automatic logic [23:0] e = exp_q.pop_front();
        automatic string t = tag_q.pop_front();
        if ({rsp_err, rsp_ctrl, rsp_bank, rsp_offset} !== e) begin
          fails++;
          $display("FAIL %s: got %h expected %h", t, {rsp_err, rsp_ctrl, rsp_bank, rsp_offset}, e);
        end
      end
    end
  end

  task automatic send(input string t, input logic [1:0] p, input logic [21:0] o);
    exp_q.push_back(model(m_mode, m_s1, m_s3, p, o));
    tag_q.push_back(t);
    @(posedge clk); #1;
    rsp_ready = 1'b1; req_valid = 1'b1; req_port = p; req_offset = o;
    @(negedge clk);
  endtask

  task automatic idle();
    @(posedge clk); #1;
    req_valid = 1'b0;
  endtask

  task automatic do_reset();
    @(posedge clk); #1;
    rst_n = 1'b0; req_valid = 1'b0; m_mode = 2'd0; m_s1 = 1'b0; m_s3 = 1'b0;
    repeat (2) @(posedge clk);
    #1 rst_n = 1'b1;
  endtask

  task automatic boot(input logic [1:0] md);
    @(posedge clk); #1;
    req_valid = 1'b0; boot_cfg_valid = 1'b1; boot_cfg_mode = md;
    @(posedge clk); #1;
    boot_cfg_valid = 1'b0;
  endtask

  task automatic do_swap(input logic s1, input logic s3);
    @(posedge clk); #1;
    req_valid = 1'b0; swap_wr = 1'b1; swap_cpu1 = s1; swap_cpu3 = s3;
    @(posedge clk); #1;
    swap_wr = 1'b0; m_s1 = s1; m_s3 = s3;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    do_reset();
    // R1 reset state
    send("R1", 2'd0, 22'h0);
    send("R4", 2'd0, 22'h000010);
    send("R4", 2'd0, 22'h0ABCDE);
    send("R5", 2'd0, 22'h3FFFFF);
    send("R9", 2'd1, 22'h0);
    send("R9", 2'd2, 22'h0);
    send("R10", 2'd3, 22'h03FFFF);
    send("R9", 2'd3, 22'h040000);
    do_swap(1'b1, 1'b1);
    send("R7", 2'd0, 22'h100000);
    send("R7", 2'd0, 22'h200030);

    // Mode 1
    do_reset(); boot(2'd1); m_mode = 2'd1;
    send("R5", 2'd0, 22'h000020);
    send("R5", 2'd0, 22'h1FFFFF);
    send("R9", 2'd0, 22'h200000);
    send("R5", 2'd2, 22'h0);
    send("R9", 2'd1, 22'h0);
    do_swap(1'b1, 1'b0);
    send("R6", 2'd0, 22'h0);
    send("R6", 2'd2, 22'h100010);
    send("R10", 2'd3, 22'h012345);
    do_swap(1'b0, 1'b0);
    // R8: swap write under a stalled CPU1 request is held back
    @(posedge clk); #1;
    rsp_ready = 1'b0; req_valid = 1'b1; req_port = 2'd0; req_offset = 22'h0;
    swap_wr = 1'b1; swap_cpu1 = 1'b1; swap_cpu3 = 1'b0;
    @(posedge clk); #1 swap_wr = 1'b0;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      check("R8", {rsp_err, rsp_ctrl, rsp_bank, rsp_offset}, 24'h0);
      check("R11", {22'h0, rsp_valid, req_ready}, 24'h2);
    end
    @(posedge clk); #1 req_valid = 1'b0; rsp_ready = 1'b1;
    @(posedge clk); #1;
    m_s1 = 1'b1;
    send("R8", 2'd0, 22'h0);

    // Mode 2, plus a late boot word that must be ignored
    do_reset(); boot(2'd2); m_mode = 2'd2;
    boot(2'd0);
    send("R2", 2'd1, 22'h100010);
    send("R5", 2'd0, 22'h1F0000);
    send("R9", 2'd0, 22'h200000);
    send("R9", 2'd2, 22'h0);
    do_swap(1'b1, 1'b1);
    send("R7", 2'd1, 22'h000000);
    send("R7", 2'd0, 22'h100000);

    // Mode 3; the no-CPU3 instance must fall back to mode 0
    do_reset(); boot(2'd3); m_mode = 2'd3;
    send("R5", 2'd0, 22'h0);
    check("R3", {n_rsp_err, n_rsp_ctrl, n_rsp_bank, n_rsp_offset},
          model(2'd0, 1'b0, 1'b0, 2'd0, 22'h0));
    send("R9", 2'd0, 22'h300000);
    check("R3", {n_rsp_err, n_rsp_ctrl, n_rsp_bank, n_rsp_offset},
          model(2'd0, 1'b0, 1'b0, 2'd0, 22'h300000));
    send("R5", 2'd1, 22'h0);
    check("R3", {n_rsp_err, n_rsp_ctrl, n_rsp_bank, n_rsp_offset}, 24'h800000);
    send("R5", 2'd2, 22'h0);
    send("R5", 2'd2, 22'h100000);
    send("R9", 2'd2, 22'h200000);
    do_swap(1'b1, 1'b0);
    send("R6", 2'd0, 22'h000010);
    send("R6", 2'd2, 22'h0);
    send("R6", 2'd1, 22'h0);
    do_swap(1'b1, 1'b1);
    send("R6", 2'd1, 22'h0);
    send("R6", 2'd2, 22'h100000);
    idle();
    repeat (2) @(posedge clk);

    checks++;
    if (exp_q.size() != 0) begin
      fails++;
      $display("FAIL R11: got %0d pending expected 0", exp_q.size());
    end
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule